// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry, Overflow and Condition Flags

This block is the combinational add/subtract datapath of a 32-bit RISC-style integer core. Each cycle the issue stage presents an opcode, two register operands, a sign-extended 16-bit immediate, a flag saying that the instruction's first-register field is zero, and the live carry (CA), overflow (OV) and summary-overflow (SO) bits. It also presents the overflow-enable (`oe`) and record (`rc`) options. In the same cycle the unit returns the result, the next CA/OV/SO values, and a 4-bit condition field with a write enable.

The opcode space covers plain, carrying, extended, minus-one and zero-extended adds, the immediate adds including the shifted form, subtract-from with a register or an immediate, absolute value, and difference-or-zero with a register or an immediate. The two remaining codes are reserved. The first register field is read as a literal zero only in the immediate-add forms. The option bits take effect only on the register forms. The carry-path structure can be chosen as a plain adder or as a carry-select adder.

Top module: `ixa_arith_unit`

## Requirements
- R1: Opcode 0 (plain add) returns `op_a + op_b` modulo 2^32. It ignores `ca_in`, and `ca_out` equals `ca_in`.
- R2: Opcode 1 (add-carrying) returns `op_a + op_b`, and `ca_out` is the carry out of bit 31.
- R3: Opcode 2 returns `op_a + op_b + ca_in`. Opcode 3 returns `op_a + 0xFFFFFFFF + ca_in`. Opcode 4 returns `op_a + ca_in`. For all three, `ca_out` is the carry out of bit 31.
- R4: Opcodes 5 (add-immediate), 6 (add-immediate-shifted), 7 (add-immediate-carrying) and 8 (add-immediate-carrying-record) use 0 in place of `op_a` when `ra_is_zero` is 1. Opcode 6 adds `imm` shifted left by 16. Opcodes 5 and 6 leave CA unchanged; opcodes 7 and 8 write the carry out into CA.
- R5: Opcode 9 returns `~op_a + op_b + 1` and opcode 10 returns `~op_a + sext(imm) + 1`. In both, `ca_out` is the carry out of bit 31.
- R6: Opcode 11 (absolute value) returns |op_a| and leaves CA unchanged. An input of 0x80000000 comes back as 0x80000000 and counts as an overflow.
- R7: Opcode 12 (difference-or-zero) returns 0 when `op_a` > `op_b` as signed values, and `~op_a + op_b + 1` otherwise. Opcode 13 does the same with `sext(imm)` in place of `op_b`. Both leave CA unchanged.
- R8: With `oe`=1 on a register form (opcodes 0-4, 9, 11, 12), `ov_out` is the signed overflow of the operation. A zeroed difference-or-zero does not overflow. With `oe`=0, or on any immediate form, `ov_out` equals `ov_in`.
- R9: The condition field is written (`cr_we`=1) when `rc`=1 on a register form, and always for opcode 8. Its bits are [3]=LT, [2]=GT, [1]=EQ, [0]=SO: the result compared as a signed value with zero, plus the updated SO. When it is not written, `cr_out` is 0.
- R10: `so_out` is `so_in` OR (`oe` in effect AND new overflow). SO is never cleared.
- R11: Opcodes 14 and 15 return 0 and do not write the condition field. CA, OV and SO pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field, sign-extended inside |
| ra_is_zero | input | 1 | First-register field of the instruction is zero |
| ca_in | input | 1 | Current carry bit |
| ov_in | input | 1 | Current overflow bit |
| so_in | input | 1 | Current summary-overflow bit |
| oe | input | 1 | Overflow-enable option |
| rc | input | 1 | Record option |
| result | output | 32 | Operation result |
| ca_out | output | 1 | Next carry bit |
| ov_out | output | 1 | Next overflow bit |
| so_out | output | 1 | Next summary-overflow bit |
| cr_out | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we | output | 1 | Condition field write enable |

## Verification
The unit holds no state, so the assertions are immediate checks. They assume that every input is a settled 0 or 1 whenever the combinational logic evaluates. The bench meets this by changing all inputs together on the falling clock edge and comparing several nanoseconds later. The stimulus covers every opcode, including the reserved ones. Operands are drawn from the full range but are biased toward 0, 1, all-ones, the most negative value and the most positive value, so that carry, overflow and the absolute-value edge are hit often. Directed vectors pin down the cases where the zero field, the shifted immediate and the option bits interact.

// File: rtl/ixa_pkg.sv
package ixa_pkg;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_ADDC   = 4'd1,
      OP_ADDE   = 4'd2,
      OP_ADDME  = 4'd3,
      OP_ADDZE  = 4'd4,
      OP_ADDI   = 4'd5,
      OP_ADDIS  = 4'd6,
      OP_ADDIC  = 4'd7,
      OP_ADDICR = 4'd8,
      OP_SUBFC  = 4'd9,
      OP_SUBFI  = 4'd10,
      OP_ABS    = 4'd11,
      OP_DOZ    = 4'd12,
      OP_DOZI   = 4'd13,
      OP_RSV14  = 4'd14,
      OP_RSV15  = 4'd15
   } ixa_op_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } ixa_cr_t;

   function automatic logic ixa_is_reg_form(ixa_op_e o);
      return (o == OP_ADD) || (o == OP_ADDC) || (o == OP_ADDE) ||
             (o == OP_ADDME) || (o == OP_ADDZE) || (o == OP_SUBFC) ||
             (o == OP_ABS) || (o == OP_DOZ);
   endfunction

   function automatic logic ixa_uses_zero_field(ixa_op_e o);
      return (o == OP_ADDI) || (o == OP_ADDIS) || (o == OP_ADDIC) ||
             (o == OP_ADDICR);
   endfunction

   function automatic logic ixa_writes_ca(ixa_op_e o);
      return (o == OP_ADDC) || (o == OP_ADDE) || (o == OP_ADDME) ||
             (o == OP_ADDZE) || (o == OP_ADDIC) || (o == OP_ADDICR) ||
             (o == OP_SUBFC) || (o == OP_SUBFI);
   endfunction

   function automatic logic ixa_is_reserved(ixa_op_e o);
      return (o == OP_RSV14) || (o == OP_RSV15);
   endfunction

endpackage

// File: rtl/ixa_operand_sel.sv
module ixa_operand_sel
   import ixa_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16
) (
   input  ixa_op_e          op,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             ra_is_zero,
   input  logic             ca_in,
   output logic [WIDTH-1:0] add_x,
   output logic [WIDTH-1:0] add_y,
   output logic             add_cin,
   output logic [WIDTH-1:0] cmp_rhs
);

   localparam int MSB     = WIDTH - 1;
   localparam int EXT_LO  = WIDTH - IMM_W;
   localparam int EXT_HI  = WIDTH - 2 * IMM_W;

   logic [WIDTH-1:0] imm_lo;
   logic [WIDTH-1:0] imm_hi;
   logic [WIDTH-1:0] base_a;

   assign imm_lo = {{EXT_LO{imm[IMM_W-1]}}, imm};

   generate
      if (EXT_HI == 0) begin : g_hi_exact
         assign imm_hi = {imm, {IMM_W{1'b0}}};
      end else begin : g_hi_ext
         assign imm_hi = {{EXT_HI{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
      end
   endgenerate

   assign base_a = (ixa_uses_zero_field(op) && ra_is_zero) ? '0 : op_a;

   always_comb begin
      add_x   = op_a;
      add_y   = op_b;
      add_cin = 1'b0;
      cmp_rhs = op_b;
      unique case (op)
         OP_ADD, OP_ADDC: begin
            add_x = op_a;
            add_y = op_b;
         end
         OP_ADDE: begin
            add_y   = op_b;
            add_cin = ca_in;
         end
         OP_ADDME: begin
            add_y   = '1;
            add_cin = ca_in;
         end
         OP_ADDZE: begin
            add_y   = '0;
            add_cin = ca_in;
         end
         OP_ADDI, OP_ADDIC, OP_ADDICR: begin
            add_x = base_a;
            add_y = imm_lo;
         end
         OP_ADDIS: begin
            add_x = base_a;
            add_y = imm_hi;
         end
         OP_SUBFC, OP_DOZ: begin
            add_x   = ~op_a;
            add_y   = op_b;
            add_cin = 1'b1;
            cmp_rhs = op_b;
         end
         OP_SUBFI, OP_DOZI: begin
            add_x   = ~op_a;
            add_y   = imm_lo;
            add_cin = 1'b1;
            cmp_rhs = imm_lo;
         end
         OP_ABS: begin
            add_x   = op_a[MSB] ? ~op_a : op_a;
            add_y   = '0;
            add_cin = op_a[MSB];
         end
         default: begin
            add_x   = '0;
            add_y   = '0;
            add_cin = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (ixa_uses_zero_field(op) && ra_is_zero) begin
         p_zero_field_r4: assert (add_x == '0)
            else $error("zero field did not force a zero operand");
      end
   end

endmodule

// File: rtl/ixa_adder.sv
module ixa_adder #(
   parameter int WIDTH        = 32,
   parameter bit CARRY_SELECT = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int MSB  = WIDTH - 1;
   localparam int LO_W = WIDTH / 2;
   localparam int HI_W = WIDTH - LO_W;

   generate
      if (!CARRY_SELECT) begin : g_plain
         logic [WIDTH:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[MSB:0];
         assign cout = full[WIDTH];
      end else begin : g_csel
         logic [LO_W:0] lo;
         logic [HI_W:0] hi0;
         logic [HI_W:0] hi1;
         assign lo  = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} +
                      {{LO_W{1'b0}}, cin};
         assign hi0 = {1'b0, x[MSB:LO_W]} + {1'b0, y[MSB:LO_W]};
         assign hi1 = {1'b0, x[MSB:LO_W]} + {1'b0, y[MSB:LO_W]} +
                      {{HI_W{1'b0}}, 1'b1};
         assign sum  = {(lo[LO_W] ? hi1[HI_W-1:0] : hi0[HI_W-1:0]),
                        lo[LO_W-1:0]};
         assign cout = lo[LO_W] ? hi1[HI_W] : hi0[HI_W];
      end
   endgenerate

   logic into_msb;
   assign into_msb = x[MSB] ^ y[MSB] ^ sum[MSB];
   assign ovf      = into_msb ^ cout;

   always_comb begin
      if (x[MSB] == y[MSB] && sum[MSB] == x[MSB]) begin
         p_no_false_ovf_r8: assert (!ovf)
            else $error("overflow reported without sign change");
      end
   end

endmodule

// File: rtl/ixa_flag_gen.sv
module ixa_flag_gen
   import ixa_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  ixa_op_e          op,
   input  logic [WIDTH-1:0] result,
   input  logic             add_cout,
   input  logic             add_ovf,
   input  logic             zeroed,
   input  logic             oe,
   input  logic             rc,
   input  logic             ca_in,
   input  logic             ov_in,
   input  logic             so_in,
   output logic             ca_out,
   output logic             ov_out,
   output logic             so_out,
   output ixa_cr_t          cr_out,
   output logic             cr_we
);

   localparam int MSB = WIDTH - 1;

   logic oe_eff;
   logic rc_eff;
   logic ov_new;

   assign oe_eff = oe && ixa_is_reg_form(op);
   assign rc_eff = (rc && ixa_is_reg_form(op)) || (op == OP_ADDICR);
   assign ov_new = add_ovf && !zeroed;

   always_comb begin
      ca_out = ixa_writes_ca(op) ? add_cout : ca_in;
      ov_out = oe_eff ? ov_new : ov_in;
      so_out = so_in | (oe_eff & ov_new);
      cr_we  = rc_eff;
      cr_out = '0;
      if (rc_eff) begin
         cr_out.lt = result[MSB];
         cr_out.eq = (result == '0);
         cr_out.gt = !result[MSB] && (result != '0);
         cr_out.so = so_out;
      end
   end

   always_comb begin
      if (op == OP_ADD) begin
         p_plain_add_ca_r1: assert (ca_out == ca_in)
            else $error("plain add changed carry");
      end
      if (so_in) begin
         p_so_sticky_r10: assert (so_out)
            else $error("summary overflow cleared");
      end
      if (!oe) begin
         p_ov_hold_r8: assert (ov_out == ov_in)
            else $error("overflow changed without enable");
      end
      if (cr_we) begin
         p_cr_so_copy_r9: assert (cr_out.so == so_out)
            else $error("condition SO differs from SO");
         p_cr_onehot_r9: assert ($onehot({cr_out.lt, cr_out.gt, cr_out.eq}))
            else $error("condition compare bits not one-hot");
      end else begin
         p_cr_quiet_r9: assert (cr_out == '0)
            else $error("condition field driven without write");
      end
   end

endmodule

// File: rtl/ixa_arith_unit.sv
module ixa_arith_unit
   import ixa_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int IMM_W        = 16,
   parameter bit CARRY_SELECT = 1'b0
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             ra_is_zero,
   input  logic             ca_in,
   input  logic             ov_in,
   input  logic             so_in,
   input  logic             oe,
   input  logic             rc,
   output logic [WIDTH-1:0] result,
   output logic             ca_out,
   output logic             ov_out,
   output logic             so_out,
   output logic [3:0]       cr_out,
   output logic             cr_we
);

   localparam int MSB = WIDTH - 1;

   generate
      if (IMM_W < 1 || WIDTH < 2 * IMM_W) begin : g_bad_widths
         $error("ixa_arith_unit: WIDTH must hold a shifted immediate");
      end
   endgenerate

   ixa_op_e          op_e;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] cmp_rhs;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;
   logic             doz_op;
   logic             zeroed;
   ixa_cr_t          cr_s;

   assign op_e = ixa_op_e'(op);

   ixa_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
      .op         (op_e),
      .op_a       (op_a),
      .op_b       (op_b),
      .imm        (imm),
      .ra_is_zero (ra_is_zero),
      .ca_in      (ca_in),
      .add_x      (add_x),
      .add_y      (add_y),
      .add_cin    (add_cin),
      .cmp_rhs    (cmp_rhs)
   );

   ixa_adder #(.WIDTH(WIDTH), .CARRY_SELECT(CARRY_SELECT)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   assign doz_op = (op_e == OP_DOZ) || (op_e == OP_DOZI);
   assign zeroed = doz_op && ($signed(op_a) > $signed(cmp_rhs));

   always_comb begin
      if (ixa_is_reserved(op_e) || zeroed) result = '0;
      else                                 result = sum;
   end

   ixa_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .op       (op_e),
      .result   (result),
      .add_cout (cout),
      .add_ovf  (ovf),
      .zeroed   (zeroed),
      .oe       (oe),
      .rc       (rc),
      .ca_in    (ca_in),
      .ov_in    (ov_in),
      .so_in    (so_in),
      .ca_out   (ca_out),
      .ov_out   (ov_out),
      .so_out   (so_out),
      .cr_out   (cr_s),
      .cr_we    (cr_we)
   );

   assign cr_out = cr_s;

   always_comb begin
      if (ixa_is_reserved(op_e)) begin
         p_reserved_quiet_r11: assert (result == '0 && !cr_we &&
                                       ca_out == ca_in && ov_out == ov_in &&
                                       so_out == so_in)
            else $error("reserved opcode had an effect");
      end
      if (op_e == OP_ABS && op_a != {1'b1, {MSB{1'b0}}}) begin
         p_abs_sign_r6: assert (!result[MSB])
            else $error("absolute value negative");
      end
      if (doz_op && !zeroed) begin
         p_doz_nonneg_r7: assert (!result[MSB] || ovf)
            else $error("difference-or-zero negative without overflow");
      end
   end

endmodule

// File: tb/ixa_arith_unit_bench.sv
module ixa_arith_unit_bench;

   typedef struct packed {
      logic [31:0] res;
      logic        ca;
      logic        ov;
      logic        so;
      logic [3:0]  cr;
      logic        we;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [15:0] imm = '0;
   logic        ra_is_zero = 1'b0;
   logic        ca_in = 1'b0;
   logic        ov_in = 1'b0;
   logic        so_in = 1'b0;
   logic        oe = 1'b0;
   logic        rc = 1'b0;
   logic [31:0] result;
   logic        ca_out;
   logic        ov_out;
   logic        so_out;
   logic [3:0]  cr_out;
   logic        cr_we;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ixa_arith_unit u_ixa_arith_unit (
      .op(op), .op_a(op_a), .op_b(op_b), .imm(imm), .ra_is_zero(ra_is_zero),
      .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in), .oe(oe), .rc(rc),
      .result(result), .ca_out(ca_out), .ov_out(ov_out), .so_out(so_out),
      .cr_out(cr_out), .cr_we(cr_we)
   );

   function automatic logic sovf(longint s);
      return (s > 64'sd2147483647) || (s < -64'sd2147483648);
   endfunction

   function automatic longint sx(logic [31:0] v);
      return longint'($signed(v));
   endfunction

   function automatic exp_t model(logic [3:0] o, logic [31:0] a, logic [31:0] b,
                                  logic [15:0] im, logic z, logic ci, logic oi,
                                  logic si, logic oen, logic rcn);
      exp_t e;
      logic [32:0] w;
      logic [31:0] si32, base;
      logic ovn, regf, oe_e, rc_e;
      longint d;
      si32 = {{16{im[15]}}, im};
      base = (z && (o inside {5, 6, 7, 8})) ? 32'h0 : a;
      e.ca = ci; ovn = 1'b0; e.res = '0;
      case (o)
         0: begin e.res = a + b; ovn = sovf(sx(a) + sx(b)); end
         1: begin w = {1'b0, a} + {1'b0, b}; e.res = w[31:0]; e.ca = w[32];
                  ovn = sovf(sx(a) + sx(b)); end
         2: begin w = {1'b0, a} + {1'b0, b} + 33'(ci); e.res = w[31:0];
                  e.ca = w[32]; ovn = sovf(sx(a) + sx(b) + longint'(ci)); end
         3: begin w = {1'b0, a} + 33'h0FFFFFFFF + 33'(ci); e.res = w[31:0];
                  e.ca = w[32]; ovn = sovf(sx(a) - 1 + longint'(ci)); end
         4: begin w = {1'b0, a} + 33'(ci); e.res = w[31:0]; e.ca = w[32];
                  ovn = sovf(sx(a) + longint'(ci)); end
         5: e.res = base + si32;
         6: e.res = base + {im, 16'h0};
         7, 8: begin w = {1'b0, base} + {1'b0, si32}; e.res = w[31:0];
                  e.ca = w[32]; end
         9: begin w = {1'b0, ~a} + {1'b0, b} + 33'd1; e.res = w[31:0];
                  e.ca = w[32]; ovn = sovf(sx(~a) + sx(b) + 1); end
         10: begin w = {1'b0, ~a} + {1'b0, si32} + 33'd1; e.res = w[31:0];
                  e.ca = w[32]; end
         11: begin e.res = a[31] ? (32'h0 - a) : a; ovn = (a == 32'h80000000); end
         12, 13: begin
            logic [31:0] r;
            r = (o == 12) ? b : si32;
            if (sx(a) > sx(r)) e.res = '0;
            else begin d = sx(r) - sx(a); e.res = d[31:0]; ovn = sovf(d); end
         end
         default: e.res = '0;
      endcase
      regf = o inside {0, 1, 2, 3, 4, 9, 11, 12};
      oe_e = oen && regf;
      rc_e = (rcn && regf) || (o == 8);
      e.ov = oe_e ? ovn : oi;
      e.so = si | (oe_e & ovn);
      e.we = rc_e;
      e.cr = rc_e ? {e.res[31], (!e.res[31] && e.res != 0), (e.res == 0), e.so}
                  : 4'h0;
      return e;
   endfunction

   function automatic string tag_of(logic [3:0] o);
      case (o)
         0: return "R1";
         1: return "R2";
         2, 3, 4: return "R3";
         5, 6, 7, 8: return "R4";
         9, 10: return "R5";
         11: return "R6";
         12, 13: return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, logic z, logic ci, logic oi, logic si,
                        logic oen, logic rcn, string tag);
      exp_t e;
      @(negedge clk);
      op = o; op_a = a; op_b = b; imm = im; ra_is_zero = z;
      ca_in = ci; ov_in = oi; so_in = si; oe = oen; rc = rcn;
      #3;
      e = model(o, a, b, im, z, ci, oi, si, oen, rcn);
      checks++;
      if (result !== e.res || ca_out !== e.ca || ov_out !== e.ov ||
          so_out !== e.so || cr_out !== e.cr || cr_we !== e.we) begin
         failures++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h: got res=%h ca=%b ov=%b so=%b cr=%h we=%b expected res=%h ca=%b ov=%b so=%b cr=%h we=%b",
                  tag, o, a, b, im, result, ca_out, ov_out, so_out, cr_out,
                  cr_we, e.res, e.ca, e.ov, e.so, e.cr, e.we);
      end
   endtask

   function automatic logic [31:0] pick();
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      case (k)
         0: return 32'h0;
         1: return 32'h1;
         2: return 32'hFFFFFFFF;
         3: return 32'h80000000;
         4: return 32'h7FFFFFFF;
         default: return $urandom;
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state: all-zero inputs give a zero result and no flags (R1)
      apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      // R1: plain add ignores carry
      apply(0, 32'hFFFFFFFF, 32'h1, 0, 0, 1, 0, 0, 0, 0, "R1");
      // R2: carry out
      apply(1, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 0, 0, 0, 0, "R2");
      // R3: extended forms with carry in
      apply(2, 32'hFFFFFFFF, 32'h0, 0, 0, 1, 0, 0, 0, 0, "R3");
      apply(3, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R3");
      apply(3, 32'h5, 32'h0, 0, 0, 1, 0, 0, 0, 0, "R3");
      apply(4, 32'hFFFFFFFF, 32'h0, 0, 0, 1, 0, 0, 0, 0, "R3");
      // R4: zero field and shifted immediate
      apply(5, 32'h1234, 0, 16'hFFFF, 1, 0, 0, 0, 0, 0, "R4");
      apply(6, 32'h10, 0, 16'h8001, 0, 1, 0, 0, 1, 1, "R4");
      apply(7, 32'hFFFF0000, 0, 16'h8000, 1, 1, 0, 0, 0, 0, "R4");
      apply(8, 32'h1, 0, 16'hFFFF, 0, 0, 0, 1, 0, 0, "R4");
      // R5: subtract-from
      apply(9, 32'h5, 32'h3, 0, 0, 0, 0, 0, 1, 1, "R5");
      apply(10, 32'h0, 0, 16'h0000, 0, 0, 0, 0, 0, 0, "R5");
      // R6: absolute value edge
      apply(11, 32'h80000000, 0, 0, 0, 0, 0, 0, 1, 1, "R6");
      apply(11, 32'hFFFFFFF9, 0, 0, 0, 1, 1, 0, 0, 0, "R6");
      // R7: signed comparison, zeroed and not zeroed
      apply(12, 32'h00000001, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 1, 1, "R7");
      apply(12, 32'h80000000, 32'h7FFFFFFF, 0, 0, 0, 0, 0, 1, 1, "R7");
      apply(13, 32'hFFFFFFF0, 0, 16'hFFF8, 0, 0, 0, 0, 0, 0, "R7");
      // R8: oe ignored on an immediate form, OV passes through
      apply(10, 32'h7FFFFFFF, 0, 16'h8000, 0, 0, 1, 0, 1, 0, "R8");
      // R9: rc ignored on an immediate form
      apply(5, 32'h0, 0, 16'h0000, 0, 0, 0, 0, 0, 1, "R9");
      // R10: SO stays set when no overflow happens
      apply(0, 32'h1, 32'h1, 0, 0, 0, 1, 1, 1, 1, "R10");
      // R11: reserved codes
      apply(14, 32'h12345678, 32'h1, 16'h1, 0, 1, 1, 1, 1, 1, "R11");
      apply(15, 32'h80000000, 32'h80000000, 0, 0, 0, 0, 0, 1, 1, "R11");
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] o;
         logic [4:0] fl;
         o  = 4'($urandom_range(0, 15));
         fl = 5'($urandom);
         apply(o, pick(), pick(), 16'($urandom), ($urandom_range(0, 3) == 0),
               fl[0], fl[1], fl[2], fl[3], fl[4], tag_of(o));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule